// File: doc/BRIEF.md
# Match-Triggered Watchdog Timer

This peripheral is a watchdog built around a free-running up-counter and a comparator. Software sets a match value, which is the timeout multiplied by the counter tick rate. For example, a 13 MHz tick and a 60 s timeout give 780,000,000, which fits in 32 bits. Software then enables counting. When the counter reaches the match value while it is running, a set of independently enabled actions fires on the same clock edge. The actions are: latch an interrupt, clear and halt the counter, raise a held internal reset request, start an external reset pulse of programmable length, and update a match output pin.

To keep the watchdog alive, software requests a counter clear and then polls the counter register until it reads zero. The clear is not immediate: it lands a fixed number of clocks after the request. While software has the debug-freeze option set, a debug-halt input stops the counter. A sticky flag records that a watchdog reset path was driven. Only the power-on reset clears this flag, so the next boot can tell what caused the reset.

Registers sit on a single-cycle bus. A write takes effect at the clock edge where the write enable is high. Reads are combinational. Registers are addressed by word index taken from `regAddr[ADDR_W-1:2]`, and an access whose two low address bits are not zero is ignored.

Top module: `wdt_match_timer`

## Requirements
- R1: After reset, every register reads 0 and irq, intRstReq, extRstOut, matchOut and wdtResetFlag are low. The register word offsets are: 0x00 status, 0x04 control, 0x08 counter, 0x0C action enables, 0x10 match value, 0x14 match-pin control, 0x18 pulse length, 0x1C reset cause.
- R2: While control bit 0 is 1, the counter (offset 0x08) increases by one on every clock and wraps modulo 2^CNT_W.
- R3: While control bit 2 is 1 and dbgHalt is high, the counter holds its value. With control bit 2 at 0, dbgHalt has no effect.
- R4: Writing 1 to control bit 1 leaves the counter unchanged for CLR_DELAY-1 clocks. The counter is zero exactly CLR_DELAY clocks after the write edge. Control bit 1 reads 1 while the clear is pending and 0 afterwards.
- R5: A match occurs when the counter is running and equals the match value (offset 0x10). If action bit 0 is set, a match sets status bit 0, and irq follows status bit 0. Without action bit 0 the status stays 0. Writing 1 to status bit 0 clears it, and writing 0 to it changes nothing.
- R6: With action bit 2 set, a match clears the counter on that edge. The counter then stays at 0 until a requested clear completes, after which counting resumes.
- R7: With action bit 3 set, a match raises intRstReq, which stays high until rstN. Action bit 5 drives intRstReq high for as long as it is set.
- R8: With action bit 4 set, a match drives extRstOut high for exactly PULSE_LEN+PULSE_EXTRA clocks, where PULSE_LEN is the value at offset 0x18 (PULSE_W bits). Action bit 6 drives extRstOut high for as long as it is set.
- R9: Match-pin control bits 5:4 select what a match does to bit 0: 0 holds it, 1 clears it, 2 sets it, 3 inverts it. Bit 0 is writable and drives matchOut.
- R10: wdtResetFlag (offset 0x1C bit 0) is set on the clock after intRstReq or extRstOut is high. It ignores writes and rstN, and only porN clears it.
- R11: Writes to the counter register (offset 0x08) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| porN | input | 1 | Power-on reset, active low, clears the reset-cause flag |
| rstN | input | 1 | System reset, active low, clears all other state |
| dbgHalt | input | 1 | Debug halt indication |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Combinational read data |
| irq | output | 1 | Match interrupt |
| intRstReq | output | 1 | Internal reset request |
| extRstOut | output | 1 | External reset pulse |
| matchOut | output | 1 | Match output pin state |
| wdtResetFlag | output | 1 | Sticky watchdog-reset cause flag |

## Verification
The bench builds the block with an 8-bit counter and a 4-bit pulse length, and leaves the clear delay at 2 and the pulse extension at 6. The narrow counter lets a wrap past 2^CNT_W happen within a few hundred clocks. The 4-bit pulse field lets the longest external pulse (15+6 clocks) be measured edge by edge, next to a short one. Every match action is reached with small match values, so repeated matches can exercise all four match-pin modes in turn.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Register word indices (byte offset / 4)
  localparam int unsigned IDX_STATUS = 0;
  localparam int unsigned IDX_CTRL   = 1;
  localparam int unsigned IDX_COUNT  = 2;
  localparam int unsigned IDX_ACTION = 3;
  localparam int unsigned IDX_MATCH  = 4;
  localparam int unsigned IDX_PIN    = 5;
  localparam int unsigned IDX_PULSE  = 6;
  localparam int unsigned IDX_CAUSE  = 7;

  // Control bits
  localparam int unsigned CB_RUN    = 0;
  localparam int unsigned CB_CLEAR  = 1;
  localparam int unsigned CB_FREEZE = 2;

  // Action-enable bits
  localparam int unsigned AB_IRQ      = 0;
  localparam int unsigned AB_STOP     = 2;
  localparam int unsigned AB_INTRST   = 3;
  localparam int unsigned AB_EXTRST   = 4;
  localparam int unsigned AB_FORCEINT = 5;
  localparam int unsigned AB_FORCEEXT = 6;
  localparam logic [6:0]  ACTION_MASK = 7'h7D;

  typedef enum logic [1:0] {
    PIN_HOLD   = 2'd0,
    PIN_LOW    = 2'd1,
    PIN_HIGH   = 2'd2,
    PIN_TOGGLE = 2'd3
  } pin_act_e;

  // Strobes from the control block to the counting datapath
  typedef struct packed {
    logic run;
    logic clearNow;
    logic stopOnMatch;
    logic pulseStart;
  } strobe_t;

endpackage

// File: rtl/wdt_count_path.sv
module wdt_count_path
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned PULSE_W     = 16,
  parameter int unsigned PULSE_EXTRA = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [CNT_W-1:0]   matchVal,
  input  logic [PULSE_W-1:0] pulseLen,
  output logic [CNT_W-1:0]   cntVal,
  output logic               hit,
  output logic               pulseActive
);

  localparam int unsigned PCNT_W = PULSE_W + $clog2(PULSE_EXTRA + 1) + 1;

  logic [PCNT_W-1:0] pulseRem;

  assign hit         = strb.run && (cntVal == matchVal);
  assign pulseActive = (pulseRem != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (strb.clearNow) begin
      cntVal <= '0;
    end else if (hit && strb.stopOnMatch) begin
      cntVal <= '0;
    end else if (strb.run) begin
      cntVal <= cntVal + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseRem <= '0;
    end else if (strb.pulseStart) begin
      pulseRem <= PCNT_W'(pulseLen) + PCNT_W'(PULSE_EXTRA);
    end else if (pulseRem != '0) begin
      pulseRem <= pulseRem - 1'b1;
    end
  end

endmodule

// File: rtl/wdt_reg_ctrl.sv
module wdt_reg_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned PULSE_W   = 16,
  parameter int unsigned CLR_DELAY = 2
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               rstN,
  input  logic               dbgHalt,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [CNT_W-1:0]   cntVal,
  input  logic               hit,
  input  logic               pulseActive,
  output strobe_t            strb,
  output logic [CNT_W-1:0]   matchVal,
  output logic [PULSE_W-1:0] pulseLen,
  output logic               irq,
  output logic               intRstReq,
  output logic               extRstOut,
  output logic               matchOut,
  output logic               wdtResetFlag
);

  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam int unsigned DLY_W = $clog2(CLR_DELAY + 1);

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             wrStatus, wrCtrl, wrAction, wrMatch, wrPin, wrPulse;

  logic             runEn;
  logic             freezeEn;
  logic [DLY_W-1:0] clrDly;
  logic             stopped;
  logic [6:0]       actBits;
  logic             intStat;
  logic             intLatch;
  logic             pinState;
  pin_act_e         pinAct;
  logic             causeFlag;

  assign wordIdx  = regAddr[ADDR_W-1:2];
  assign aligned  = (regAddr[1:0] == 2'b00);
  assign wrStatus = regWrEn && aligned && (wordIdx == IDX_W'(IDX_STATUS));
  assign wrCtrl   = regWrEn && aligned && (wordIdx == IDX_W'(IDX_CTRL));
  assign wrAction = regWrEn && aligned && (wordIdx == IDX_W'(IDX_ACTION));
  assign wrMatch  = regWrEn && aligned && (wordIdx == IDX_W'(IDX_MATCH));
  assign wrPin    = regWrEn && aligned && (wordIdx == IDX_W'(IDX_PIN));
  assign wrPulse  = regWrEn && aligned && (wordIdx == IDX_W'(IDX_PULSE));

  // Strobes toward the datapath
  always_comb begin
    strb.run         = runEn && !(freezeEn && dbgHalt) && !stopped;
    strb.clearNow    = (clrDly == DLY_W'(1));
    strb.stopOnMatch = actBits[AB_STOP];
    strb.pulseStart  = hit && actBits[AB_EXTRST];
  end

  // Control register and delayed clear sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn    <= 1'b0;
      freezeEn <= 1'b0;
      clrDly   <= '0;
    end else begin
      if (wrCtrl) begin
        runEn    <= regWrData[CB_RUN];
        freezeEn <= regWrData[CB_FREEZE];
      end
      if (wrCtrl && regWrData[CB_CLEAR]) begin
        clrDly <= DLY_W'(CLR_DELAY);
      end else if (clrDly != '0) begin
        clrDly <= clrDly - 1'b1;
      end
    end
  end

  // Halt-after-match state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopped <= 1'b0;
    end else if (strb.clearNow) begin
      stopped <= 1'b0;
    end else if (hit && actBits[AB_STOP]) begin
      stopped <= 1'b1;
    end
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actBits  <= '0;
      matchVal <= '0;
      pulseLen <= '0;
    end else begin
      if (wrAction) actBits  <= regWrData[6:0] & ACTION_MASK;
      if (wrMatch)  matchVal <= regWrData[CNT_W-1:0];
      if (wrPulse)  pulseLen <= regWrData[PULSE_W-1:0];
    end
  end

  // Interrupt status: set on match wins over write-one-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intStat <= 1'b0;
    end else if (hit && actBits[AB_IRQ]) begin
      intStat <= 1'b1;
    end else if (wrStatus && regWrData[0]) begin
      intStat <= 1'b0;
    end
  end

  // Internal reset request latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intLatch <= 1'b0;
    end else if (hit && actBits[AB_INTRST]) begin
      intLatch <= 1'b1;
    end
  end

  // Match output pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinState <= 1'b0;
      pinAct   <= PIN_HOLD;
    end else if (wrPin) begin
      pinState <= regWrData[0];
      pinAct   <= pin_act_e'(regWrData[5:4]);
    end else if (hit) begin
      case (pinAct)
        PIN_LOW:    pinState <= 1'b0;
        PIN_HIGH:   pinState <= 1'b1;
        PIN_TOGGLE: pinState <= ~pinState;
        default:    pinState <= pinState;
      endcase
    end
  end

  assign irq       = intStat;
  assign intRstReq = intLatch | actBits[AB_FORCEINT];
  assign extRstOut = pulseActive | actBits[AB_FORCEEXT];
  assign matchOut  = pinState;

  // Reset cause flag lives in the power-on domain
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      causeFlag <= 1'b0;
    end else if (intRstReq || extRstOut) begin
      causeFlag <= 1'b1;
    end
  end

  assign wdtResetFlag = causeFlag;

  // Read mux
  always_comb begin
    regRdData = '0;
    if (aligned) begin
      case (wordIdx)
        IDX_W'(IDX_STATUS): regRdData = DATA_W'(intStat);
        IDX_W'(IDX_CTRL):   regRdData = DATA_W'({freezeEn, (clrDly != '0), runEn});
        IDX_W'(IDX_COUNT):  regRdData = DATA_W'(cntVal);
        IDX_W'(IDX_ACTION): regRdData = DATA_W'(actBits);
        IDX_W'(IDX_MATCH):  regRdData = DATA_W'(matchVal);
        IDX_W'(IDX_PIN):    regRdData = DATA_W'({pinAct, 3'b000, pinState});
        IDX_W'(IDX_PULSE):  regRdData = DATA_W'(pulseLen);
        IDX_W'(IDX_CAUSE):  regRdData = DATA_W'(causeFlag);
        default:            regRdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/wdt_match_timer.sv
module wdt_match_timer
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned PULSE_W     = 16,
  parameter int unsigned PULSE_EXTRA = 6,
  parameter int unsigned CLR_DELAY   = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              dbgHalt,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq,
  output logic              intRstReq,
  output logic              extRstOut,
  output logic              matchOut,
  output logic              wdtResetFlag
);

  strobe_t            strb;
  logic [CNT_W-1:0]   cntVal;
  logic [CNT_W-1:0]   matchVal;
  logic [PULSE_W-1:0] pulseLen;
  logic               hit;
  logic               pulseActive;

  wdt_reg_ctrl #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .PULSE_W  (PULSE_W),
    .CLR_DELAY(CLR_DELAY)
  ) u_ctrl (
    .clk         (clk),
    .porN        (porN),
    .rstN        (rstN),
    .dbgHalt     (dbgHalt),
    .regAddr     (regAddr),
    .regWrEn     (regWrEn),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .cntVal      (cntVal),
    .hit         (hit),
    .pulseActive (pulseActive),
    .strb        (strb),
    .matchVal    (matchVal),
    .pulseLen    (pulseLen),
    .irq         (irq),
    .intRstReq   (intRstReq),
    .extRstOut   (extRstOut),
    .matchOut    (matchOut),
    .wdtResetFlag(wdtResetFlag)
  );

  wdt_count_path #(
    .CNT_W      (CNT_W),
    .PULSE_W    (PULSE_W),
    .PULSE_EXTRA(PULSE_EXTRA)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .matchVal   (matchVal),
    .pulseLen   (pulseLen),
    .cntVal     (cntVal),
    .hit        (hit),
    .pulseActive(pulseActive)
  );

endmodule

// File: rtl/wdt_match_timer_chk.sv
module wdt_match_timer_chk
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              porN,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic              irq,
  input logic              intRstReq,
  input logic              extRstOut,
  input logic              wdtResetFlag,
  input strobe_t           strb,
  input logic [CNT_W-1:0]  cntVal,
  input logic              hit
);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!porN)
    wdtResetFlag |=> wdtResetFlag);

  p_flag_set_r10: assert property (@(posedge clk) disable iff (!porN)
    (intRstReq || extRstOut) |=> wdtResetFlag);

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.clearNow) |=> $stable(cntVal));

  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearNow |=> (cntVal == '0));

  p_stop_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hit && strb.stopOnMatch) |=> (cntVal == '0));

  p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(regWrEn && regAddr == ADDR_W'(0) && regWrData[0])) |=> irq);

endmodule

bind wdt_match_timer wdt_match_timer_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk         (clk),
  .porN        (porN),
  .rstN        (rstN),
  .regAddr     (regAddr),
  .regWrEn     (regWrEn),
  .regWrData   (regWrData),
  .irq         (irq),
  .intRstReq   (intRstReq),
  .extRstOut   (extRstOut),
  .wdtResetFlag(wdtResetFlag),
  .strb        (strb),
  .cntVal      (cntVal),
  .hit         (hit)
);

// File: tb/wdt_match_timer_test.sv
module wdt_match_timer_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic        rstN = 1'b0;
  logic        dbgHalt = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irq, intRstReq, extRstOut, matchOut, wdtResetFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wdt_match_timer #(
    .CNT_W  (8),
    .PULSE_W(4)
  ) uut (
    .clk(clk), .porN(porN), .rstN(rstN), .dbgHalt(dbgHalt),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq), .intRstReq(intRstReq),
    .extRstOut(extRstOut), .matchOut(matchOut), .wdtResetFlag(wdtResetFlag)
  );

  // {kind[2], req[4], addr[5], data[32], expected[32]}; kind 0 write, 1 read, 2 idle
  localparam logic [74:0] VEC [NVEC] = '{
    {2'd1, 4'd1,  5'h04, 32'd0,    32'd0},  // R1 control
    {2'd1, 4'd1,  5'h08, 32'd0,    32'd0},  // R1 counter
    {2'd1, 4'd1,  5'h0C, 32'd0,    32'd0},  // R1 actions
    {2'd1, 4'd1,  5'h1C, 32'd0,    32'd0},  // R1 cause flag
    {2'd0, 4'd8,  5'h18, 32'd3,    32'd0},
    {2'd1, 4'd8,  5'h18, 32'd0,    32'd3},  // R8 pulse length storage
    {2'd0, 4'd5,  5'h10, 32'd5,    32'd0},
    {2'd0, 4'd11, 5'h08, 32'h77,   32'd0},
    {2'd1, 4'd11, 5'h08, 32'd0,    32'd0},  // R11 counter not writable
    {2'd0, 4'd2,  5'h04, 32'd1,    32'd0},
    {2'd2, 4'd2,  5'h00, 32'd3,    32'd0},
    {2'd1, 4'd2,  5'h08, 32'd0,    32'd3},  // R2 counting
    {2'd2, 4'd2,  5'h00, 32'd4,    32'd0},
    {2'd1, 4'd5,  5'h00, 32'd0,    32'd0},  // R5 no status without enable
    {2'd1, 4'd2,  5'h08, 32'd0,    32'd7}   // R2 counted past match
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdCheck(input string tag, input logic [4:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    check(tag, regRdData, exp);
  endtask

  task automatic doReset(input bit withPor);
    rstN = 1'b0;
    if (withPor) porN = 1'b0;
    idle(2);
    rstN = 1'b1;
    porN = 1'b1;
    idle(1);
  endtask

  task automatic clearCounter();
    wrReg(5'h04, 32'd2);
    idle(1);
  endtask

  task automatic runToMatch(input int m);
    clearCounter();
    wrReg(5'h10, 32'(m));
    wrReg(5'h04, 32'd1);
    idle(m + 1);
  endtask

  task automatic measurePulse(output int n);
    n = 0;
    while (extRstOut && n < 100) begin
      n++;
      idle(1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pw;
    @(negedge clk);
    doReset(1'b1);
    check("R1 irq", 32'(irq), 0);
    check("R1 outputs", 32'({intRstReq, extRstOut, matchOut, wdtResetFlag}), 0);

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][74:73])
        2'd0: wrReg(VEC[i][68:64], VEC[i][63:32]);
        2'd1: rdCheck($sformatf("R%0d", VEC[i][72:69]), VEC[i][68:64], VEC[i][31:0]);
        default: idle(int'(VEC[i][63:32]));
      endcase
    end

    // R4: delayed counter clear (counter was 7, running, steps to 8 on write edge)
    wrReg(5'h04, 32'd2);
    rdCheck("R4 not cleared at once", 5'h08, 32'd8);
    rdCheck("R4 pending bit", 5'h04, 32'd2);
    idle(1);
    rdCheck("R4 one clock later", 5'h08, 32'd8);
    idle(1);
    rdCheck("R4 cleared", 5'h08, 32'd0);
    rdCheck("R4 pending done", 5'h04, 32'd0);

    // R2: wrap
    wrReg(5'h10, 32'hFF);
    wrReg(5'h04, 32'd1);
    idle(260);
    rdCheck("R2 wrap", 5'h08, 32'd4);

    // R3: debug freeze
    clearCounter();
    wrReg(5'h04, 32'd5);
    idle(3);
    dbgHalt = 1'b1;
    idle(4);
    rdCheck("R3 frozen", 5'h08, 32'd3);
    wrReg(5'h04, 32'd1);
    idle(2);
    rdCheck("R3 halt ignored without freeze", 5'h08, 32'd5);
    dbgHalt = 1'b0;

    // R5: match interrupt
    wrReg(5'h0C, 32'h1);
    clearCounter();
    wrReg(5'h10, 32'd10);
    wrReg(5'h04, 32'd1);
    idle(10);
    check("R5 no irq before match", 32'(irq), 0);
    idle(1);
    check("R5 irq on match", 32'(irq), 1);
    rdCheck("R5 status set", 5'h00, 32'd1);
    wrReg(5'h00, 32'd0);
    rdCheck("R5 write zero keeps", 5'h00, 32'd1);
    wrReg(5'h00, 32'd1);
    rdCheck("R5 write one clears", 5'h00, 32'd0);
    check("R5 irq cleared", 32'(irq), 0);

    // R6: stop on match
    wrReg(5'h0C, 32'h4);
    clearCounter();
    wrReg(5'h10, 32'd6);
    wrReg(5'h04, 32'd1);
    idle(6);
    rdCheck("R6 reaches match", 5'h08, 32'd6);
    idle(1);
    rdCheck("R6 cleared on match", 5'h08, 32'd0);
    idle(5);
    rdCheck("R6 stays stopped", 5'h08, 32'd0);
    wrReg(5'h04, 32'd3);
    idle(2);
    idle(3);
    rdCheck("R6 resumes after clear", 5'h08, 32'd3);

    // R7: internal reset request
    wrReg(5'h0C, 32'h8);
    clearCounter();
    wrReg(5'h10, 32'd4);
    wrReg(5'h04, 32'd1);
    idle(4);
    check("R7 low before match", 32'(intRstReq), 0);
    idle(1);
    check("R7 raised on match", 32'(intRstReq), 1);
    idle(3);
    check("R7 held", 32'(intRstReq), 1);
    check("R10 flag set", 32'(wdtResetFlag), 1);
    wrReg(5'h1C, 32'd0);
    rdCheck("R10 flag ignores write", 5'h1C, 32'd1);
    doReset(1'b0);
    check("R7 cleared by rstN", 32'(intRstReq), 0);
    rdCheck("R1 control after rstN", 5'h04, 32'd0);
    rdCheck("R10 flag survives rstN", 5'h1C, 32'd1);
    doReset(1'b1);
    check("R10 flag cleared by porN", 32'(wdtResetFlag), 0);
    wrReg(5'h0C, 32'h20);
    check("R7 forced", 32'(intRstReq), 1);
    wrReg(5'h0C, 32'h0);
    check("R7 force released", 32'(intRstReq), 0);
    doReset(1'b1);

    // R8: external pulse
    wrReg(5'h18, 32'd3);
    wrReg(5'h0C, 32'h10);
    wrReg(5'h10, 32'd2);
    wrReg(5'h04, 32'd1);
    idle(2);
    check("R8 low before match", 32'(extRstOut), 0);
    idle(1);
    measurePulse(pw);
    check("R8 short pulse width", 32'(pw), 32'd9);
    check("R10 flag from pulse", 32'(wdtResetFlag), 1);
    clearCounter();
    wrReg(5'h18, 32'd15);
    wrReg(5'h04, 32'd1);
    idle(3);
    measurePulse(pw);
    check("R8 longest pulse width", 32'(pw), 32'd21);
    doReset(1'b1);
    wrReg(5'h0C, 32'h40);
    check("R8 forced", 32'(extRstOut), 1);
    wrReg(5'h0C, 32'h0);
    check("R8 force released", 32'(extRstOut), 0);
    doReset(1'b1);

    // R9: match output pin modes
    wrReg(5'h14, 32'h20);
    check("R9 pin low", 32'(matchOut), 0);
    rdCheck("R9 pin reg", 5'h14, 32'h20);
    runToMatch(3);
    check("R9 set on match", 32'(matchOut), 1);
    rdCheck("R9 pin reg set", 5'h14, 32'h21);
    wrReg(5'h14, 32'h31);
    runToMatch(3);
    check("R9 toggled", 32'(matchOut), 0);
    wrReg(5'h14, 32'h01);
    runToMatch(3);
    check("R9 held", 32'(matchOut), 1);
    wrReg(5'h14, 32'h11);
    runToMatch(3);
    check("R9 cleared on match", 32'(matchOut), 0);
    rdCheck("R9 pin reg cleared", 5'h14, 32'h10);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule